// File: doc/BRIEF.md
# Multiplexed Address/Data Pin Controller

This block lets an external memory bus reuse one general-purpose port for two jobs: the low address byte and the data byte. It does not make bus timing itself. A separate timing generator supplies an address-phase strobe and a write strobe. From those strobes, the block works out for each pin whether a pin override is active and which value it carries. Three pin properties are covered: the pull-up, the output direction and the driven level.

While the bus is enabled, the pins drive the address byte during the address phase and the write byte during a write. In every other phase the pins are released, and a weak pull-up holds the bus level if the port's own bit asks for one and pull-ups are not switched off globally. Bit n of the port carries address bit n and data bit n. Read data comes straight from the pins' digital inputs. When the bus is disabled, every override drops, so the normal port registers control the pins again.

The block is purely combinational. It has no clock and no reset.

Top module: `addr_data_pinmux`

## Requirements
- R1: While `xm_en` is 1, every bit of `pu_ovr_en`, `dir_ovr_en` and `val_ovr_en` is 1. While `xm_en` is 0, every bit of these three outputs is 0.
- R2: While `xm_en` is 0, `pu_ovr_val`, `dir_ovr_val`, `val_ovr_val` and `bus_clash` are all 0, whatever the other inputs are.
- R3: While `xm_en` is 1, every bit of `dir_ovr_val` equals (`addr_phase` OR `wr_phase`). A value of 1 means the pin drives.
- R4: While `xm_en` is 1:
  - in the address phase, `val_ovr_val[n]` equals `addr_lo[n]`;
  - with only `wr_phase` high, `val_ovr_val[n]` equals `wr_data[n]`;
  - with neither strobe high, `val_ovr_val` is 0.
- R5: While `xm_en` is 1, `pu_ovr_val[n]` is 1 only when all of these hold: neither strobe is high, `port_bits[n]` is 1, and `pud` is 0. A value of 1 means the pull-up is on.
- R6: `din_ovr_en` and `din_ovr_val` are 0 on every pin at all times.
- R7: `rd_data[n]` equals `pin_in[n]` for every n, whatever the mode.
- R8: While `xm_en` is 1, if both strobes are high together, `val_ovr_val` carries `addr_lo` and `bus_clash` is 1. In every other case `bus_clash` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xm_en | input | 1 | External memory bus enable |
| addr_phase | input | 1 | High while the address byte is put out |
| wr_phase | input | 1 | High while write data is put out |
| pud | input | 1 | Global pull-up disable |
| addr_lo | input | 8 | Low address byte |
| wr_data | input | 8 | Write data byte |
| port_bits | input | 8 | Port output register bits (pull-up request) |
| pin_in | input | 8 | Digital input from each pin |
| pu_ovr_en | output | 8 | Pull-up override enable |
| pu_ovr_val | output | 8 | Pull-up override value |
| dir_ovr_en | output | 8 | Direction override enable |
| dir_ovr_val | output | 8 | Direction override value (1 = drive) |
| val_ovr_en | output | 8 | Driven-value override enable |
| val_ovr_val | output | 8 | Driven-value override value |
| din_ovr_en | output | 8 | Digital input enable override enable |
| din_ovr_val | output | 8 | Digital input enable override value |
| rd_data | output | 8 | Read data returned to the bus |
| bus_clash | output | 1 | Both strobes high at once |

## Verification
The checker re-tests these relations whenever an input changes:
- the three override enables always agree with each other;
- a pin that drives never has its pull-up on;
- a disabled bus forces every value to zero;
- a strobe clash always puts the address on the pins.

Only the bench's scenarios can show that each pin takes the correct bit of the address or data byte, how the pull-up depends on the port bit and on `pud`, and that read data follows the pins.

// File: rtl/addr_data_pinmux.sv
module addr_data_pinmux #(
  parameter int W = 8
) (
  input  logic         xm_en,
  input  logic         addr_phase,
  input  logic         wr_phase,
  input  logic         pud,
  input  logic [W-1:0] addr_lo,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] port_bits,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pu_ovr_en,
  output logic [W-1:0] pu_ovr_val,
  output logic [W-1:0] dir_ovr_en,
  output logic [W-1:0] dir_ovr_val,
  output logic [W-1:0] val_ovr_en,
  output logic [W-1:0] val_ovr_val,
  output logic [W-1:0] din_ovr_en,
  output logic [W-1:0] din_ovr_val,
  output logic [W-1:0] rd_data,
  output logic         bus_clash
);

  logic driving;
  logic idle;

  assign driving   = xm_en & (addr_phase | wr_phase);
  assign idle      = xm_en & ~(addr_phase | wr_phase);
  assign bus_clash = xm_en & addr_phase & wr_phase;

  for (genvar n = 0; n < W; n++) begin : g_pin
    assign pu_ovr_en[n]   = xm_en;
    assign dir_ovr_en[n]  = xm_en;
    assign val_ovr_en[n]  = xm_en;
    assign din_ovr_en[n]  = 1'b0;
    assign din_ovr_val[n] = 1'b0;
    assign dir_ovr_val[n] = driving;
    assign pu_ovr_val[n]  = idle & port_bits[n] & ~pud;
    assign val_ovr_val[n] = xm_en & (addr_phase ? addr_lo[n] : (wr_phase & wr_data[n]));
    assign rd_data[n]     = pin_in[n];
  end

endmodule

module addr_data_pinmux_chk #(
  parameter int W = 8
) (
  input logic         xm_en,
  input logic         addr_phase,
  input logic [W-1:0] addr_lo,
  input logic [W-1:0] pu_ovr_en,
  input logic [W-1:0] pu_ovr_val,
  input logic [W-1:0] dir_ovr_en,
  input logic [W-1:0] dir_ovr_val,
  input logic [W-1:0] val_ovr_en,
  input logic [W-1:0] val_ovr_val,
  input logic         bus_clash
);

  always_comb begin
    // R1
    enables_agree_chk: assert (pu_ovr_en == dir_ovr_en && dir_ovr_en == val_ovr_en);
    // R5
    no_pullup_while_drive_chk: assert ((pu_ovr_val & dir_ovr_val) == '0);
    // R2
    idle_bus_quiet_chk: assert (xm_en || (pu_ovr_val == '0 && dir_ovr_val == '0 &&
                                           val_ovr_val == '0 && !bus_clash));
    // R8
    clash_addr_wins_chk: assert (!bus_clash || (addr_phase && val_ovr_val == addr_lo &&
                                                 dir_ovr_val == '1));
  end

endmodule

bind addr_data_pinmux addr_data_pinmux_chk #(.W(W)) u_chk (
  .xm_en(xm_en), .addr_phase(addr_phase), .addr_lo(addr_lo),
  .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val),
  .dir_ovr_en(dir_ovr_en), .dir_ovr_val(dir_ovr_val),
  .val_ovr_en(val_ovr_en), .val_ovr_val(val_ovr_val),
  .bus_clash(bus_clash)
);

// File: tb/addr_data_pinmux_test.sv
module addr_data_pinmux_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic xm_en, addr_phase, wr_phase, pud;
  logic [W-1:0] addr_lo, wr_data, port_bits, pin_in;
  logic [W-1:0] pu_ovr_en, pu_ovr_val, dir_ovr_en, dir_ovr_val;
  logic [W-1:0] val_ovr_en, val_ovr_val, din_ovr_en, din_ovr_val, rd_data;
  logic bus_clash;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  addr_data_pinmux #(.W(W)) uut (.*);

  function automatic logic [W-1:0] exp_val();
    if (!xm_en) return '0;
    if (addr_phase) return addr_lo;
    if (wr_phase) return wr_data;
    return '0;
  endfunction

  function automatic logic [W-1:0] exp_pu();
    if (!xm_en || addr_phase || wr_phase || pud) return '0;
    return port_bits;
  endfunction

  function automatic logic [W-1:0] exp_dir();
    return (xm_en && (addr_phase || wr_phase)) ? '1 : '0;
  endfunction

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (en=%b a=%b w=%b pud=%b)",
               tag, act, exp, xm_en, addr_phase, wr_phase, pud);
    end
  endtask

  task automatic check_all();
    logic [W-1:0] en_exp;
    en_exp = xm_en ? '1 : '0;
    cmp("R1 pu_en", pu_ovr_en, en_exp);
    cmp("R1 dir_en", dir_ovr_en, en_exp);
    cmp("R1 val_en", val_ovr_en, en_exp);
    cmp(xm_en ? "R3 dir_val" : "R2 dir_val", dir_ovr_val, exp_dir());
    cmp(xm_en ? "R4 val" : "R2 val", val_ovr_val, exp_val());
    cmp(xm_en ? "R5 pu_val" : "R2 pu_val", pu_ovr_val, exp_pu());
    cmp("R6 din_en", din_ovr_en, '0);
    cmp("R6 din_val", din_ovr_val, '0);
    cmp("R7 rd_data", rd_data, pin_in);
    cmp("R8 clash", {{(W-1){1'b0}}, bus_clash},
        {{(W-1){1'b0}}, xm_en & addr_phase & wr_phase});
  endtask

  task automatic apply(input logic e, input logic a, input logic w, input logic p,
                       input logic [W-1:0] ad, input logic [W-1:0] wd,
                       input logic [W-1:0] pb, input logic [W-1:0] pi);
    @(negedge clk);
    xm_en = e; addr_phase = a; wr_phase = w; pud = p;
    addr_lo = ad; wr_data = wd; port_bits = pb; pin_in = pi;
    #2;
    check_all();
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    xm_en = 0; addr_phase = 0; wr_phase = 0; pud = 0;
    addr_lo = '0; wr_data = '0; port_bits = '0; pin_in = '0;
    #3;
    check_all();
    // R2: disabled bus ignores strobes and data
    apply(0, 1, 1, 0, 8'hFF, 8'hFF, 8'hFF, 8'h3C);
    apply(0, 0, 0, 0, 8'hA5, 8'h5A, 8'hFF, 8'hC3);
    // R4: address phase, then write, then idle
    apply(1, 1, 0, 0, 8'h81, 8'h7E, 8'hFF, 8'h00);
    apply(1, 0, 1, 0, 8'h81, 8'h7E, 8'hFF, 8'h00);
    apply(1, 0, 0, 0, 8'h81, 8'h7E, 8'hFF, 8'h96);
    // R5: read phase with pull-ups globally off, and partial port bits
    apply(1, 0, 0, 1, 8'h00, 8'h00, 8'hFF, 8'h69);
    apply(1, 0, 0, 0, 8'h00, 8'h00, 8'h5A, 8'h69);
    // R8: both strobes high, address wins
    apply(1, 1, 1, 0, 8'hC3, 8'h3C, 8'hFF, 8'h11);
    // single-bit walks for R4 bit placement
    for (int i = 0; i < W; i++) begin
      apply(1, 1, 0, 0, 8'(1 << i), 8'h00, 8'h00, 8'(1 << i));
      apply(1, 0, 1, 0, 8'h00, 8'(1 << i), 8'h00, 8'h00);
    end
    for (int k = 0; k < 400; k++) begin
      logic [3:0] ctl;
      ctl = 4'($urandom());
      apply(ctl[0] | ctl[3], ctl[1], ctl[2] & ~(ctl[1] & k[0]), 1'($urandom() % 4 == 0),
            8'($urandom()), 8'($urandom()), 8'($urandom()), 8'($urandom()));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule